// File: doc/BRIEF.md
# Quad DAC Serial Control Front End

This block is the digital control side of a four-channel voltage-output converter. A host writes 24-bit frames over a three-wire serial link made of an active-low frame sync, a serial clock and a data line. Bits are sent MSB first and are sampled on the falling edges of the serial clock. The block decodes each complete frame into a command, a channel address and a 12-bit code. It then updates a two-stage register pair for each channel: a staging register followed by an output code register. It also sets a per-channel power-down mode.

All three serial lines are brought into the system clock domain through two-flop synchronizers. Serial clock edges are detected in that domain, so the serial clock must run several times slower than the system clock. A frame takes effect only on its 24th falling edge. If sync returns high before that edge, the frame is abandoned. Any edges after the 24th are ignored until sync goes high and then low again. The four output codes and the four mode fields go to the analog core.

Top module: `qdac_serial_ctrl`

## Requirements
- R1: After reset, every output code is 0 and every power-down mode is 00 (normal). Codes stay at 0 until a frame changes them.
- R2: Command 000 loads the data field into the staging register of each addressed channel. No output code changes.
- R3: Command 001 copies the staging register into the output code register of each addressed channel. Other channels are left unchanged.
- R4: Command 010 loads the data into the addressed staging registers and, in the same step, copies every channel's staging register into its output code. An addressed channel therefore shows the new data.
- R5: Command 011 writes the data into both the staging register and the output code of the addressed channels only.
- R6: The address field selects channels as follows: 000 selects A, 001 selects B, 010 selects C, 011 selects D, and 111 selects all four. Addresses 100, 101 and 110 select no channel.
- R7: Command 100 sets the mode to frame bits 5:4 for every channel whose bit is set in frame bits 3:0 (bit 0 is A, bit 3 is D). Other channels keep their mode. The modes are: 00 normal, 01 1k load, 10 100k load, 11 tri-state.
- R8: Command 111 clears all staging registers, all output codes and all modes to zero.
- R9: If sync rises before the 24th falling edge, the frame changes nothing.
- R10: Falling edges after the 24th, while sync is still low, change nothing.
- R11: The frame layout is as follows. Bits 23:22 are ignored. Bits 21:19 are the command. Bits 18:16 are the address. Bits 15:4 are the data. Bits 3:0 are ignored by every command except 100.
- R12: Commands 101 and 110 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| fs_n | input | 1 | Frame sync, active low |
| sclk | input | 1 | Serial clock; data is sampled on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| dac_code | output | 48 | Four 12-bit output codes; channel A in bits 11:0 |
| pd_mode | output | 8 | Four 2-bit power-down modes; channel A in bits 1:0 |

## Verification
Command 010 writes a staging register and moves all staging registers to the outputs in the same clock edge. The addressed channel must therefore show the freshly written data, not its stale staging value. The other channels must show their previously staged values. This case is provoked by staging distinct values on every channel with command 000 and then issuing 010, both for one channel and for all channels. The bench judges the result against a reference model that applies the write before the transfer. Random frames mix this case with truncated and over-long frames.

// File: rtl/qdac_serial_ctrl.sv
module qdac_serial_ctrl #(
  parameter int CH = 4,
  parameter int DW = 12,
  parameter int FW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fs_n,
  input  logic            sclk,
  input  logic            sdin,
  output logic [CH*DW-1:0] dac_code,
  output logic [CH*2-1:0]  pd_mode
);
  localparam int CW = $clog2(FW);
  localparam int WW = DW + 10;

  logic [2:0] fs_q, sck_q, sd_q;
  logic active;
  logic [CW-1:0] cnt;
  logic [WW-2:0] sr;
  logic [WW-1:0] word;
  logic frame_done, fall, fs_start;
  logic [2:0] cmd, addr;
  logic [DW-1:0] data;
  logic [CH-1:0] sel;
  logic [DW-1:0] inreg [CH];
  logic [DW-1:0] dacr [CH];
  logic [1:0] pd [CH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fs_q <= '1; sck_q <= '1; sd_q <= '0;
    end else begin
      fs_q <= {fs_q[1:0], fs_n};
      sck_q <= {sck_q[1:0], sclk};
      sd_q <= {sd_q[1:0], sdin};
    end

  assign fall = sck_q[2] & ~sck_q[1];
  assign fs_start = fs_q[2] & ~fs_q[1];
  assign word = {sr, sd_q[1]};
  assign frame_done = active & fall & (cnt == CW'(FW-1));
  assign cmd = word[DW+9:DW+7];
  assign addr = word[DW+6:DW+4];
  assign data = word[DW+3:4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0; cnt <= '0; sr <= '0;
    end else if (fs_q[1]) begin
      active <= 1'b0;
    end else if (fs_start) begin
      active <= 1'b1; cnt <= '0;
    end else if (active && fall) begin
      sr <= {sr[WW-3:0], sd_q[1]};
      cnt <= cnt + CW'(1);
      if (cnt == CW'(FW-1)) active <= 1'b0;
    end

  always_comb
    for (int i = 0; i < CH; i++)
      sel[i] = (addr == 3'd7) || (addr == 3'(i));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < CH; i++) begin
        inreg[i] <= '0; dacr[i] <= '0; pd[i] <= 2'b00;
      end
    end else if (frame_done) begin
      case (cmd)
        3'b000: for (int i = 0; i < CH; i++) if (sel[i]) inreg[i] <= data;
        3'b001: for (int i = 0; i < CH; i++) if (sel[i]) dacr[i] <= inreg[i];
        3'b010:
          for (int i = 0; i < CH; i++)
            if (sel[i]) begin inreg[i] <= data; dacr[i] <= data; end
            else dacr[i] <= inreg[i];
        3'b011:
          for (int i = 0; i < CH; i++)
            if (sel[i]) begin inreg[i] <= data; dacr[i] <= data; end
        3'b100: for (int i = 0; i < CH; i++) if (word[i]) pd[i] <= word[5:4];
        3'b111:
          for (int i = 0; i < CH; i++) begin
            inreg[i] <= '0; dacr[i] <= '0; pd[i] <= 2'b00;
          end
        default: ;
      endcase
    end

  for (genvar g = 0; g < CH; g++) begin : g_out
    assign dac_code[g*DW +: DW] = dacr[g];
    assign pd_mode[g*2 +: 2] = pd[g];
  end
endmodule

// File: rtl/qdac_serial_ctrl_chk.sv
module qdac_serial_ctrl_chk #(
  parameter int CH = 4,
  parameter int DW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_done,
  input logic [2:0]      cmd,
  input logic [CH*DW-1:0] dac_code,
  input logic [CH*2-1:0]  pd_mode
);
  a_r2_stage_keeps_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && cmd == 3'b000 |=> $stable(dac_code) && $stable(pd_mode));
  a_r9_outputs_move_only_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(dac_code) && $stable(pd_mode));
  a_r8_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && cmd == 3'b111 |=> dac_code == '0 && pd_mode == '0);
  a_r12_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && (cmd == 3'b101 || cmd == 3'b110) |=> $stable(dac_code) && $stable(pd_mode));
  a_r7_mode_only_by_pd_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && cmd != 3'b100 && cmd != 3'b111 |=> $stable(pd_mode));
  a_r10_single_action_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

bind qdac_serial_ctrl qdac_serial_ctrl_chk #(.CH(CH), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .cmd(cmd),
  .dac_code(dac_code), .pd_mode(pd_mode));

// File: tb/qdac_serial_ctrl_tb_top.sv
module qdac_serial_ctrl_tb_top;
  logic clk = 0, rst_n = 0, fs_n = 1, sclk = 1, sdin = 0;
  logic [47:0] dac_code;
  logic [7:0] pd_mode;
  int total = 0, bad = 0;
  logic [11:0] m_in [4], m_dac [4];
  logic [1:0] m_pd [4];

  always #5 clk = ~clk;

  qdac_serial_ctrl dut_i (.clk(clk), .rst_n(rst_n), .fs_n(fs_n), .sclk(sclk),
    .sdin(sdin), .dac_code(dac_code), .pd_mode(pd_mode));

  function automatic logic [23:0] mk(logic [1:0] dc, logic [2:0] c, logic [2:0] a,
                                     logic [11:0] d, logic [3:0] lo);
    return {dc, c, a, d, lo};
  endfunction

  function automatic bit hit(logic [2:0] a, int i);
    return (a == 3'd7) || (a == 3'(i));
  endfunction

  function automatic void model(logic [23:0] w);
    logic [2:0] c = w[21:19];
    logic [2:0] a = w[18:16];
    logic [11:0] d = w[15:4];
    for (int i = 0; i < 4; i++) begin
      case (c)
        3'b000: if (hit(a, i)) m_in[i] = d;
        3'b001: if (hit(a, i)) m_dac[i] = m_in[i];
        3'b010: begin if (hit(a, i)) m_in[i] = d; m_dac[i] = m_in[i]; end
        3'b011: if (hit(a, i)) begin m_in[i] = d; m_dac[i] = d; end
        3'b100: if (w[i]) m_pd[i] = w[5:4];
        3'b111: begin m_in[i] = 0; m_dac[i] = 0; m_pd[i] = 0; end
        default: ;
      endcase
    end
  endfunction

  task automatic bitclk(logic b);
    sclk = 1; sdin = b;
    repeat (4) @(negedge clk);
    sclk = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(logic [23:0] w, int nbits, int extra);
    @(negedge clk); fs_n = 0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < nbits; k++) bitclk(w[23-k]);
    for (int k = 0; k < extra; k++) bitclk(1'($urandom));
    sclk = 1;
    repeat (4) @(negedge clk);
    fs_n = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic chk(string req);
    logic [47:0] ed;
    logic [7:0] ep;
    ed = {m_dac[3], m_dac[2], m_dac[1], m_dac[0]};
    ep = {m_pd[3], m_pd[2], m_pd[1], m_pd[0]};
    total++;
    if (dac_code !== ed || pd_mode !== ep) begin
      bad++;
      $display("FAIL %s: act code=%h pd=%b exp code=%h pd=%b", req, dac_code, pd_mode, ed, ep);
    end
  endtask

  task automatic frame(string req, logic [23:0] w);
    send(w, 24, 0); model(w); chk(req);
  endtask

  function automatic string tag(logic [2:0] c);
    case (c)
      3'b000: return "R2";
      3'b001: return "R3";
      3'b010: return "R4";
      3'b011: return "R5";
      3'b100: return "R7";
      3'b111: return "R8";
      default: return "R12";
    endcase
  endfunction

  initial begin
    #2_500_000;
    bad++; total++;
    $display("FAIL watchdog: act hung exp finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 4; i++) begin m_in[i] = 0; m_dac[i] = 0; m_pd[i] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 reset");
    for (int i = 0; i < 4; i++) frame("R2 stage", mk(0, 3'b000, 3'(i), 12'h101 * 12'(i + 1), 0));
    frame("R3 update A", mk(0, 3'b001, 3'd0, 12'h000, 0));
    frame("R4 write B + all update", mk(0, 3'b010, 3'd1, 12'hABC, 0));
    frame("R4 write all + all update", mk(0, 3'b010, 3'd7, 12'h5A5, 0));
    frame("R5 write+update D", mk(0, 3'b011, 3'd3, 12'hFFF, 0));
    frame("R6 all channels", mk(0, 3'b011, 3'd7, 12'h123, 0));
    frame("R6 unused address", mk(0, 3'b011, 3'd5, 12'h777, 0));
    frame("R7 pd mask A,C", mk(0, 3'b100, 3'd0, 12'h002, 4'b0101));
    frame("R7 pd mask D", mk(0, 3'b100, 3'd0, 12'h003, 4'b1000));
    frame("R12 reserved 101", mk(0, 3'b101, 3'd7, 12'h999, 4'hF));
    frame("R12 reserved 110", mk(0, 3'b110, 3'd7, 12'h999, 4'hF));
    frame("R11 dont-care bits", mk(2'b11, 3'b011, 3'd2, 12'h468, 4'hF));
    send(mk(0, 3'b011, 3'd7, 12'hEEE, 0), 23, 0);
    chk("R9 cancelled at 23 bits");
    send(mk(0, 3'b111, 3'd0, 12'h000, 0), 10, 0);
    chk("R9 cancelled at 10 bits");
    send(mk(0, 3'b011, 3'd1, 12'h321, 0), 24, 12);
    model(mk(0, 3'b011, 3'd1, 12'h321, 0));
    chk("R10 extra edges");
    frame("R8 soft reset", mk(0, 3'b111, 3'd0, 12'hFFF, 4'hF));
    for (int n = 0; n < 70; n++) begin
      logic [2:0] c;
      logic [23:0] w;
      int r;
      r = $urandom_range(0, 7);
      c = (r == 7) ? 3'b111 : 3'(r % 7 == 5 ? 3'b100 : r % 6);
      if ($urandom_range(0, 15) == 0) c = 3'b111;
      else if (c == 3'b111) c = 3'b000;
      w = mk(2'($urandom), c, 3'($urandom), 12'($urandom), 4'($urandom));
      case ($urandom_range(0, 9))
        0: begin send(w, $urandom_range(1, 23), 0); chk("R9 random cut"); end
        1: begin send(w, 24, $urandom_range(1, 8)); model(w); chk("R10 random tail"); end
        default: frame(tag(c), w);
      endcase
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule